// File: doc/BRIEF.md
# Rectangular Pixel-Array Transfer Address Generator

This block steers a rectangular copy into or out of a pixel store that is 1024 pixels wide and 512 rows tall, with 16 bits per pixel. A start pulse presents a position word and a size word. From then on, each 32-bit data word pushed in by the host (write direction) or pulled out by the host (read direction) moves two pixels. The block produces the pixel address for each of those two pixels and drives two synchronous single-pixel memory lanes, one per pixel, which an external RAM serves. It keeps the column offset inside the current row between words, so the host may stop and resume at any word boundary. When the column offset reaches the width, the block moves to the next row, and the row index wraps at the bottom of the array.

A read start raises an image-busy status flag. It also fetches the first word ahead of any request, so that a host word is already waiting. Both directions end with a one-cycle done pulse on the word that covers the last pixel of the last row. A start that arrives while a transfer is still running abandons the old transfer, loads the new one and flags the event with a one-cycle pulse.

Top module: `vxfer_rect_gen`

## Requirements
- R1: On a start pulse the start column is taken from position bits 9:0 and the start row from position bits 24:16. The first pixel goes to address row*1024 + column.
- R2: The width is the size field at bits 9:0 and the height is the size field at bits 24:16. A field value of 0 selects the maximum, 1024 columns or 512 rows.
- R3: Each accepted write word is split in two. Bits 15:0 go to lane 0 at the current position and bits 31:16 go to lane 1 at the following position. The memory outputs (mem_en bit i, mem_we, lane addresses and data) are registered on the same clock edge that samples the word.
- R4: After the pixel at column offset width-1, the next pixel goes to the start column of the next row, and the remaining height drops by one. The column address wraps modulo 1024.
- R5: The row address wraps modulo 512.
- R6: Idle cycles between words do not change the position: the next word continues exactly where the previous one stopped.
- R7: The word that covers the last pixel raises done for one cycle on the edge that samples it, and busy falls on that same edge. If the pixel count is odd, that word enables lane 0 only (mem_en = 2'b01).
- R8: A read start sets img_busy on the sampling edge and fetches the start word. rd_valid with rd_data (bits 15:0 from lane 0, bits 31:16 from lane 1) appears 3 cycles after the start edge, and 2 cycles after each rd_req edge. A missing final pixel reads as 0.
- R9: img_busy clears together with done on the rd_req that covers the last pixel.
- R10: A start during an active transfer raises restart_seen for one cycle, and the new parameters replace the old ones.
- R11: After reset, busy, img_busy, done, restart_seen, rd_valid, mem_we and mem_en are all 0.
- R12: While idle, or while a read is running, wr_valid causes no memory write. While idle, or while a write is running, rd_req causes no rd_valid. A start in the same cycle as either request takes precedence, and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new transfer |
| start_read | input | 1 | Direction of the transfer being started (1 = read) |
| pos_word | input | 32 | Start column in bits 9:0, start row in bits 24:16 |
| size_word | input | 32 | Width field in bits 9:0, height field in bits 24:16 |
| wr_valid | input | 1 | Write word present |
| wr_data | input | 32 | Write word, two pixels |
| rd_req | input | 1 | Host takes one read word |
| rd_valid | output | 1 | rd_data holds a fetched word |
| rd_data | output | 32 | Read word, two pixels |
| busy | output | 1 | Transfer in progress |
| img_busy | output | 1 | Read transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| restart_seen | output | 1 | One-cycle pulse: start arrived while busy |
| mem_we | output | 1 | Lane access is a write |
| mem_en | output | 2 | Per-lane access enable |
| mem_addr | output | 38 | Lane addresses, 19 bits each, lane 0 in the low bits |
| mem_wdata | output | 32 | Lane write pixels, lane 0 in the low bits |
| mem_rdata | input | 32 | Lane read pixels, one cycle after the access |

## Verification
The lane enables, addresses, write data, done, busy and img_busy all change on the edge that samples the word, the rd_req or the start. The bench therefore drives on falling edges and reads these outputs on the very next falling edge. Read data passes through the RAM register and one capture register, so the bench waits two more falling edges after an rd_req and three after a read start before it compares rd_data. Memory contents are compared one edge after the last word, once the bench RAM has committed the final write.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;
  localparam int COL_BITS  = 10;  // 1024 columns
  localparam int ROW_BITS  = 9;   // 512 rows
  localparam int PIX_BITS  = 16;
  localparam int WORD_PIX  = 2;   // pixels per host word
  localparam int ROW_FIELD = 16;  // row / height field position in host words
endpackage

// File: rtl/vxfer_decode.sv
module vxfer_decode
  import vxfer_pkg::*;
#(
  parameter int XW = COL_BITS,
  parameter int YW = ROW_BITS
) (
  input  logic [31:0] pos_word,
  input  logic [31:0] size_word,
  output logic [XW-1:0] ld_x,
  output logic [YW-1:0] ld_y,
  output logic [XW:0]   ld_w,
  output logic [YW:0]   ld_h
);
  logic [XW-1:0] wf;
  logic [YW-1:0] hf;

  assign ld_x = pos_word[XW-1:0];
  assign ld_y = pos_word[ROW_FIELD +: YW];
  assign wf   = size_word[XW-1:0];
  assign hf   = size_word[ROW_FIELD +: YW];

  // field value zero stands for the full extent
  assign ld_w = (wf == '0) ? {1'b1, {XW{1'b0}}} : {1'b0, wf};
  assign ld_h = (hf == '0) ? {1'b1, {YW{1'b0}}} : {1'b0, hf};

  logic unused_fields;
  assign unused_fields = ^{pos_word[31:ROW_FIELD+YW], pos_word[ROW_FIELD-1:XW],
                           size_word[31:ROW_FIELD+YW], size_word[ROW_FIELD-1:XW]};
endmodule

// File: rtl/vxfer_walker.sv
module vxfer_walker
  import vxfer_pkg::*;
#(
  parameter int XW    = COL_BITS,
  parameter int YW    = ROW_BITS,
  parameter int LANES = WORD_PIX
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic [XW-1:0] ld_x,
  input  logic [YW-1:0] ld_y,
  input  logic [XW:0]   ld_w,
  input  logic [YW:0]   ld_h,
  input  logic adv,
  output logic active,
  output logic finish,
  output logic [LANES-1:0] lane_ok,
  output logic [LANES*(XW+YW)-1:0] lane_addr
);
  localparam int AW = XW + YW;

  logic [XW-1:0] base_x;
  logic [XW:0]   width;
  logic [XW:0]   off_q;
  logic [YW-1:0] row_q;
  logic [YW:0]   left_q;
  logic          act_q;

  logic [XW:0]   off_c  [LANES+1];
  logic [YW-1:0] row_c  [LANES+1];
  logic [YW:0]   left_c [LANES+1];
  logic [XW:0]   nxt    [LANES];
  logic [XW-1:0] col    [LANES];

  // position chain: one step per lane, each lane sees the position after the one below it
  always_comb begin
    off_c[0]  = off_q;
    row_c[0]  = row_q;
    left_c[0] = left_q;
    for (int i = 0; i < LANES; i++) begin
      lane_ok[i] = act_q && (left_c[i] != '0);
      col[i]     = base_x + off_c[i][XW-1:0];
      lane_addr[i*AW +: AW] = {row_c[i], col[i]};
      nxt[i]     = off_c[i] + (XW+1)'(1);
      off_c[i+1]  = off_c[i];
      row_c[i+1]  = row_c[i];
      left_c[i+1] = left_c[i];
      if (lane_ok[i]) begin
        if (nxt[i] == width) begin
          off_c[i+1]  = '0;
          row_c[i+1]  = row_c[i] + YW'(1);
          left_c[i+1] = left_c[i] - (YW+1)'(1);
        end else begin
          off_c[i+1]  = nxt[i];
        end
      end
    end
  end

  assign active = act_q;
  assign finish = act_q && (left_c[LANES] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_x <= '0;
      width  <= '0;
      off_q  <= '0;
      row_q  <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
    end else if (load) begin
      base_x <= ld_x;
      width  <= ld_w;
      off_q  <= '0;
      row_q  <= ld_y;
      left_q <= ld_h;
      act_q  <= 1'b1;
    end else if (adv && act_q) begin
      off_q  <= off_c[LANES];
      row_q  <= row_c[LANES];
      left_q <= left_c[LANES];
      act_q  <= (left_c[LANES] != '0);
    end
  end
endmodule

// File: rtl/vxfer_lanes.sv
module vxfer_lanes
  import vxfer_pkg::*;
#(
  parameter int AW    = COL_BITS + ROW_BITS,
  parameter int PW    = PIX_BITS,
  parameter int LANES = WORD_PIX
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic write,
  input  logic [LANES-1:0]    lane_ok,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*PW-1:0] wdata,
  output logic                mem_we,
  output logic [LANES-1:0]    mem_en,
  output logic [LANES*AW-1:0] mem_addr,
  output logic [LANES*PW-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) mem_we <= 1'b0;
    else     mem_we <= issue && write;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_en[g]              <= 1'b0;
        mem_addr[g*AW +: AW]   <= '0;
        mem_wdata[g*PW +: PW]  <= '0;
      end else begin
        mem_en[g] <= issue && lane_ok[g];
        if (issue && lane_ok[g]) begin
          mem_addr[g*AW +: AW]  <= lane_addr[g*AW +: AW];
          mem_wdata[g*PW +: PW] <= wdata[g*PW +: PW];
        end
      end
    end
  end
endmodule

// File: rtl/vxfer_readback.sv
module vxfer_readback
  import vxfer_pkg::*;
#(
  parameter int PW    = PIX_BITS,
  parameter int LANES = WORD_PIX
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic [LANES-1:0]    lane_ok,
  input  logic [LANES*PW-1:0] mem_rdata,
  output logic                rd_valid,
  output logic [LANES*PW-1:0] rd_data
);
  logic             iss1, iss2;
  logic [LANES-1:0] msk1, msk2;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss1 <= 1'b0; iss2 <= 1'b0;
      msk1 <= '0;   msk2 <= '0;
      rd_valid <= 1'b0;
    end else begin
      iss1 <= issue;
      msk1 <= issue ? lane_ok : '0;
      iss2 <= iss1;
      msk2 <= msk1;
      rd_valid <= iss2;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) rd_data[g*PW +: PW] <= '0;
      else if (iss2) rd_data[g*PW +: PW] <= msk2[g] ? mem_rdata[g*PW +: PW] : '0;
    end
  end
endmodule

// File: rtl/vxfer_rect_gen.sv
module vxfer_rect_gen
  import vxfer_pkg::*;
#(
  parameter int XW    = COL_BITS,
  parameter int YW    = ROW_BITS,
  parameter int PW    = PIX_BITS,
  parameter int LANES = WORD_PIX
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_read,
  input  logic [31:0] pos_word,
  input  logic [31:0] size_word,
  input  logic wr_valid,
  input  logic [LANES*PW-1:0] wr_data,
  input  logic rd_req,
  output logic rd_valid,
  output logic [LANES*PW-1:0] rd_data,
  output logic busy,
  output logic img_busy,
  output logic done,
  output logic restart_seen,
  output logic mem_we,
  output logic [LANES-1:0] mem_en,
  output logic [LANES*(XW+YW)-1:0] mem_addr,
  output logic [LANES*PW-1:0] mem_wdata,
  input  logic [LANES*PW-1:0] mem_rdata
);
  localparam int AW = XW + YW;

  logic [XW-1:0] ld_x;
  logic [YW-1:0] ld_y;
  logic [XW:0]   ld_w;
  logic [YW:0]   ld_h;
  logic          act, fin;
  logic [LANES-1:0]    lane_ok;
  logic [LANES*AW-1:0] lane_addr;

  logic is_read_q, pend_q, img_q, done_q, restart_q;
  logic wr_take, rd_take, pend_iss, adv, issue;

  vxfer_decode #(.XW(XW), .YW(YW)) dec_i (
    .pos_word(pos_word), .size_word(size_word),
    .ld_x(ld_x), .ld_y(ld_y), .ld_w(ld_w), .ld_h(ld_h)
  );

  vxfer_walker #(.XW(XW), .YW(YW), .LANES(LANES)) walk_i (
    .clk(clk), .rst(rst), .load(start),
    .ld_x(ld_x), .ld_y(ld_y), .ld_w(ld_w), .ld_h(ld_h),
    .adv(adv), .active(act), .finish(fin),
    .lane_ok(lane_ok), .lane_addr(lane_addr)
  );

  // a start in the same cycle wins over any data request
  assign wr_take  = wr_valid && act && !is_read_q && !start;
  assign rd_take  = rd_req   && act &&  is_read_q && !start;
  assign pend_iss = pend_q && !start;
  assign adv      = wr_take || rd_take;
  assign issue    = adv || pend_iss;

  vxfer_lanes #(.AW(AW), .PW(PW), .LANES(LANES)) lanes_i (
    .clk(clk), .rst(rst), .issue(issue), .write(wr_take),
    .lane_ok(lane_ok), .lane_addr(lane_addr), .wdata(wr_data),
    .mem_we(mem_we), .mem_en(mem_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  vxfer_readback #(.PW(PW), .LANES(LANES)) rb_i (
    .clk(clk), .rst(rst), .issue(rd_take || pend_iss), .lane_ok(lane_ok),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      is_read_q <= 1'b0;
      pend_q    <= 1'b0;
      img_q     <= 1'b0;
      done_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      pend_q    <= start && start_read;
      restart_q <= start && act;
      done_q    <= adv && fin;
      if (start) begin
        is_read_q <= start_read;
        img_q     <= start_read;
      end else if (rd_take && fin) begin
        img_q     <= 1'b0;
      end
    end
  end

  assign busy         = act;
  assign img_busy     = img_q;
  assign done         = done_q;
  assign restart_seen = restart_q;
endmodule

// File: rtl/vxfer_rect_gen_chk.sv
module vxfer_rect_gen_chk #(
  parameter int LANES = 2
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic start_read,
  input logic wr_valid,
  input logic busy,
  input logic img_busy,
  input logic done,
  input logic restart_seen,
  input logic mem_we,
  input logic [LANES-1:0] mem_en
);
  // R3: upper lane never runs alone
  p_lane_order_r3: assert property (@(posedge clk) disable iff (rst)
    mem_en[1] |-> mem_en[0]);
  // R3: a write always carries a lane-0 pixel
  p_we_has_lane_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en[0]);
  // R12: a write strobe only follows a presented word
  p_we_from_word_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(wr_valid));
  // R1: a start makes the block busy
  p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R8: a read start raises the image flag
  p_read_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (start && start_read) |=> img_busy);
  // R7: done leaves the block idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: image flag only during a transfer
  p_img_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    img_busy |-> busy);
  // R10: restart flag only when the block was busy
  p_restart_busy_r10: assert property (@(posedge clk) disable iff (rst)
    restart_seen |-> $past(busy));
endmodule

bind vxfer_rect_gen vxfer_rect_gen_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .start(start), .start_read(start_read),
  .wr_valid(wr_valid), .busy(busy), .img_busy(img_busy), .done(done),
  .restart_seen(restart_seen), .mem_we(mem_we), .mem_en(mem_en)
);

// File: tb/vxfer_rect_gen_tb_top.sv
module vxfer_rect_gen_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, start_read, wr_valid, rd_req;
  logic [31:0] pos_word, size_word, wr_data, rd_data, mem_wdata, mem_rdata;
  logic rd_valid, busy, img_busy, done, restart_seen, mem_we;
  logic [1:0]  mem_en;
  logic [37:0] mem_addr;

  vxfer_rect_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .start_read(start_read),
    .pos_word(pos_word), .size_word(size_word), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .img_busy(img_busy), .done(done), .restart_seen(restart_seen),
    .mem_we(mem_we), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // bench pixel RAM, two synchronous lanes
  logic [15:0] ram [int];
  logic [15:0] q0, q1;
  int wcount;
  assign mem_rdata = {q1, q0};

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (mem_en[i]) begin
        if (mem_we) begin
          ram[int'(mem_addr[i*19 +: 19])] = mem_wdata[i*16 +: 16];
          wcount = wcount + 1;
        end else begin
          if (i == 0) q0 <= ram.exists(int'(mem_addr[18:0])) ? ram[int'(mem_addr[18:0])] : 16'h0;
          else        q1 <= ram.exists(int'(mem_addr[37:19])) ? ram[int'(mem_addr[37:19])] : 16'h0;
        end
      end
    end
  end

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dec_w(input int f); return (f == 0) ? 1024 : f; endfunction
  function automatic int dec_h(input int f); return (f == 0) ? 512 : f; endfunction
  function automatic int pix_addr(input int x0, input int y0, input int w, input int n);
    return ((y0 + n / w) % 512) * 1024 + (x0 + n % w) % 1024;
  endfunction
  function automatic logic [15:0] rd_pat(input int a); return 16'(a) ^ 16'h5A5A; endfunction

  task automatic begin_xfer(input int x0, input int y0, input int wf, input int hf, input bit rd);
    @(negedge clk);
    start = 1; start_read = rd;
    pos_word  = (32'(y0) << 16) | 32'(x0);
    size_word = (32'(hf) << 16) | 32'(wf);
    wcount = 0;
    @(negedge clk);
    start = 0;
  endtask

  // write scenario: streams all words, checks end-of-transfer timing, lane mask and RAM
  task automatic do_write(input int x0, input int y0, input int wf, input int hf,
                          input int gap, input int seed, input string tag);
    int w, h, npix, nw, bad, bad_a;
    logic [15:0] bad_v;
    w = dec_w(wf); h = dec_h(hf); npix = w * h; nw = (npix + 1) / 2;
    begin_xfer(x0, y0, wf, hf, 0);
    for (int j = 0; j < nw; j++) begin
      wr_valid = 1;
      wr_data  = {16'(seed + 2*j + 1), 16'(seed + 2*j)};
      @(negedge clk);
      wr_valid = 0;
      if (j == nw - 1) begin
        chk(done == 1 && busy == 0, {"R7 done/busy ", tag}, {done, busy}, 2'b10);
        chk(mem_en == ((npix % 2) ? 2'b01 : 2'b11), {"R7 R3 last lanes ", tag}, mem_en, (npix % 2) ? 1 : 3);
      end else if (j == 0) begin
        chk(mem_addr[18:0] == 19'(pix_addr(x0, y0, w, 0)) && mem_we, {"R1 first addr ", tag},
            mem_addr[18:0], pix_addr(x0, y0, w, 0));
      end
      repeat (gap) @(negedge clk);
    end
    @(negedge clk);
    chk(done == 0, {"R7 one-cycle done ", tag}, done, 0);
    chk(wcount == npix, {"R2 R7 pixel count ", tag}, wcount, npix);
    bad = 0; bad_a = 0; bad_v = 0;
    for (int n = 0; n < npix; n++) begin
      int a;
      a = pix_addr(x0, y0, w, n);
      if (!ram.exists(a) || ram[a] != 16'(seed + n)) begin
        if (bad == 0) begin bad_a = a; bad_v = ram.exists(a) ? ram[a] : 16'hx; end
        bad++;
      end
    end
    chk(bad == 0, {"R3 R4 R5 R6 contents ", tag}, bad_a, bad_v);
  endtask

  // read scenario: preload RAM, check preload word and every requested word
  task automatic do_read(input int x0, input int y0, input int wf, input int hf, input string tag);
    int w, h, npix, nw;
    logic [31:0] exp;
    w = dec_w(wf); h = dec_h(hf); npix = w * h; nw = (npix + 1) / 2;
    for (int n = 0; n < npix; n++) ram[pix_addr(x0, y0, w, n)] = rd_pat(pix_addr(x0, y0, w, n));
    begin_xfer(x0, y0, wf, hf, 1);
    chk(img_busy == 1, {"R8 img_busy set ", tag}, img_busy, 1);
    repeat (3) @(negedge clk);
    exp = {rd_pat(pix_addr(x0, y0, w, 1)), rd_pat(pix_addr(x0, y0, w, 0))};
    if (npix == 1) exp[31:16] = 16'h0;
    chk(rd_valid && rd_data == exp, {"R8 preload ", tag}, rd_data, exp);
    for (int j = 0; j < nw; j++) begin
      rd_req = 1;
      @(negedge clk);
      rd_req = 0;
      if (j == nw - 1)
        chk(done == 1 && img_busy == 0 && busy == 0, {"R9 read end ", tag}, {done, img_busy, busy}, 3'b100);
      repeat (2) @(negedge clk);
      exp[15:0]  = rd_pat(pix_addr(x0, y0, w, 2*j));
      exp[31:16] = (2*j + 1 < npix) ? rd_pat(pix_addr(x0, y0, w, 2*j + 1)) : 16'h0;
      chk(rd_valid && rd_data == exp, {"R8 R4 R5 read word ", tag}, rd_data, exp);
    end
  endtask

  task automatic t_reset();
    chk({busy, img_busy, done, restart_seen, rd_valid, mem_we, mem_en} == 0, "R11 reset state",
        {busy, img_busy, done, restart_seen, rd_valid, mem_we, mem_en}, 0);
  endtask

  task automatic t_ignore();
    // idle: write word dropped
    @(negedge clk); wr_valid = 1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); wr_valid = 0;
    chk(mem_en == 0 && mem_we == 0, "R12 idle word", {mem_en, mem_we}, 0);
    // idle: read request dropped
    rd_req = 1; @(negedge clk); rd_req = 0;
    repeat (2) @(negedge clk);
    chk(rd_valid == 0, "R12 idle rd_req", rd_valid, 0);
    // during read: write word dropped
    begin_xfer(40, 40, 2, 1, 1);
    repeat (3) @(negedge clk);
    wr_valid = 1; @(negedge clk); wr_valid = 0;
    chk(mem_we == 0 && busy == 1, "R12 word during read", {mem_we, busy}, 2'b01);
    rd_req = 1; @(negedge clk); rd_req = 0;
    chk(done == 1, "R9 short read done", done, 1);
    repeat (2) @(negedge clk);
    // during write: read request dropped, position unchanged
    begin_xfer(60, 60, 2, 1, 0);
    rd_req = 1; @(negedge clk); rd_req = 0;
    repeat (2) @(negedge clk);
    chk(rd_valid == 0 && busy == 1, "R12 rd_req during write", {rd_valid, busy}, 2'b01);
    wr_valid = 1; wr_data = 32'h2222_1111; @(negedge clk); wr_valid = 0;
    chk(done == 1 && mem_addr[18:0] == 19'(60*1024 + 60), "R12 write unaffected", mem_addr[18:0], 60*1024 + 60);
    @(negedge clk);
  endtask

  task automatic t_restart();
    begin_xfer(100, 100, 8, 2, 0);
    wr_valid = 1; wr_data = 32'h0B0B_0A0A; @(negedge clk); wr_valid = 0;
    begin_xfer(200, 50, 2, 1, 0);
    chk(restart_seen == 1 && busy == 1, "R10 restart pulse", {restart_seen, busy}, 2'b11);
    @(negedge clk);
    chk(restart_seen == 0, "R10 pulse width", restart_seen, 0);
    wr_valid = 1; wr_data = 32'h0D0D_0C0C; @(negedge clk); wr_valid = 0;
    chk(done == 1 && mem_addr[18:0] == 19'(50*1024 + 200), "R10 new position", mem_addr[18:0], 50*1024 + 200);
    @(negedge clk);
    chk(ram[50*1024 + 200] == 16'h0C0C && ram[50*1024 + 201] == 16'h0D0D, "R10 new data",
        {ram[50*1024 + 201], ram[50*1024 + 200]}, 32'h0D0D_0C0C);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    rst = 1; start = 0; start_read = 0; wr_valid = 0; rd_req = 0;
    pos_word = 0; size_word = 0; wr_data = 0; wcount = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    do_write(10, 5, 4, 2, 0, 16'h1000, "basic");
    do_write(20, 30, 3, 3, 0, 16'h2000, "odd width");
    do_write(1022, 511, 4, 2, 0, 16'h3000, "wrap");
    do_write(300, 200, 5, 3, 3, 16'h4000, "gaps");
    do_write(5, 7, 0, 1, 0, 16'h5000, "zero width");
    do_write(9, 3, 1, 0, 0, 16'h6000, "zero height");
    do_read(1023, 100, 3, 2, "read wrap");
    do_read(4, 511, 1, 3, "read odd");
    t_ignore();
    t_restart();
    finished = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end
endmodule